// File: doc/BRIEF.md
# DMA Channel FIFO Readiness and Bus Request Gate

This block sits beside the storage buffer of one DMA channel. It decides, cycle by cycle, whether the read side (source) and the write side (destination) of the channel may ask for the shared master bus. It reads the buffer's fill level in bytes and the item width of each side. It also reads the burst lengths, the remaining item count of the current burst or block, and the threshold mode. The remaining inputs are the flush and suspend states, the flow-control settings and the peripheral handshake lines.

Each side has a readiness test. In the plain test a single item must fit into the free space, or a single item must be available to read. In the threshold test a whole burst must fit, or a whole burst must be available. The threshold test falls back to the plain test near the end of a burst or block, during flush and while suspended. A request, once raised, stays up until the arbiter grants it or the channel is switched off. A registered empty flag tells the channel control when the buffer holds nothing the write side can use.

The buffer depth is chosen from the channel index. Channels 0 and 1 have a 128-byte buffer and all others a 32-byte buffer.

Top module: `dma_chan_req_gate`

## Requirements
- R1: During reset all three outputs are 0. A cycle sampled with `chan_en` = 0 leaves `src_req` and `dst_req` at 0 after the next clock edge.
- R2: The plain source test passes when free space (depth minus `fifo_bytes`, floored at 0) is at least one source item. Item width code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R3: The plain destination test passes when `fifo_bytes` is at least one destination item, using the same width coding.
- R4: While `flush` = 1 the destination test uses the source item width in place of the destination width, and the threshold test is not used on either side.
- R5: With `fifo_mode` = 1, a side whose endpoint is memory or whose burst handshake line is active uses the threshold test. Source needs free space of at least burst length × source item bytes. Destination needs `fifo_bytes` of at least burst length × destination item bytes. A side serving a single-transfer request keeps the plain test.
- R6: When a side's remaining item count is below half the depth in bytes, that side uses the plain test. At exactly half, the threshold test still applies.
- R7: While `suspend` = 1 the source raises no new request, and the destination uses the plain test.
- R8: A non-memory side raises a request only while one of its handshake lines is active. A line is active when its level differs from the side's polarity bit (polarity 1 = active low). A memory side needs only readiness.
- R9: When `dst_is_fc` = 1 and `prefetch_off` = 1, the source raises a request only while a destination handshake line is active.
- R10: A raised request is held while its grant is 0. It drops in the cycle after the grant is sampled at 1.
- R11: `fifo_empty` is 1 when `fifo_bytes` = 0. It is also 1 while suspended with source item width below destination item width and `fifo_bytes` below one destination item.
- R12: `CHAN_ID` 0 or 1 gives a 128-byte depth (half = 64). Any other `CHAN_ID` gives a 32-byte depth (half = 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enabled |
| fifo_bytes | input | 8 | Bytes currently stored in the channel buffer |
| src_wsel | input | 2 | Source item width code |
| dst_wsel | input | 2 | Destination item width code |
| src_blen | input | 8 | Source burst length in items |
| dst_blen | input | 8 | Destination burst length in items |
| src_left | input | 16 | Source items left in current burst or block |
| dst_left | input | 16 | Destination items left in current burst or block |
| fifo_mode | input | 1 | Threshold (burst-sized) readiness mode |
| flush | input | 1 | Buffer flush in progress |
| suspend | input | 1 | Channel suspended |
| src_is_mem | input | 1 | Source endpoint is memory |
| dst_is_mem | input | 1 | Destination endpoint is memory |
| dst_is_fc | input | 1 | Destination peripheral terminates the block |
| prefetch_off | input | 1 | Source pre-fetch inhibited |
| src_hs_pol | input | 1 | Source handshake polarity (1 = active low) |
| dst_hs_pol | input | 1 | Destination handshake polarity (1 = active low) |
| src_hs_single | input | 1 | Source single-transfer request line |
| src_hs_burst | input | 1 | Source burst request line |
| dst_hs_single | input | 1 | Destination single-transfer request line |
| dst_hs_burst | input | 1 | Destination burst request line |
| src_grant | input | 1 | Arbiter grant to the source side |
| dst_grant | input | 1 | Arbiter grant to the destination side |
| src_req | output | 1 | Source bus request |
| dst_req | output | 1 | Destination bus request |
| fifo_empty | output | 1 | No usable data for the destination side |

## Verification
All three outputs are registered. A change on any input shows at the outputs right after the next rising edge, with no further delay. The bench changes inputs just after a falling edge and samples one falling edge later, so exactly one rising edge lies between stimulus and check. Held requests would carry state from one vector into the next. To avoid this, each vector first spends one cycle with the channel off and is then applied with the channel on. Hold and grant behaviour is then checked in a directed sequence, one edge per step.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

    localparam int MAX_DEPTH = 128;
    localparam int CNT_W     = $clog2(MAX_DEPTH) + 1;
    localparam int BL_W      = 8;
    localparam int LEFT_W    = 16;
    localparam int MUL_W     = (CNT_W > BL_W + 3) ? CNT_W : BL_W + 3;

    typedef enum logic [1:0] {
        WID_8   = 2'd0,
        WID_16  = 2'd1,
        WID_32  = 2'd2,
        WID_32X = 2'd3
    } wid_e;

    typedef struct packed {
        logic act;    // any request line active after polarity
        logic burst;  // burst-eligible: memory endpoint or burst line active
    } hs_t;

    function automatic int depth_for(input int ch);
        return (ch < 2) ? 128 : 32;
    endfunction

    function automatic logic [MUL_W-1:0] item_bytes(input wid_e w);
        case (w)
            WID_8:   return MUL_W'(1);
            WID_16:  return MUL_W'(2);
            default: return MUL_W'(4);
        endcase
    endfunction

    function automatic logic [MUL_W-1:0] burst_bytes(input logic [BL_W-1:0] n, input wid_e w);
        case (w)
            WID_8:   return MUL_W'(n);
            WID_16:  return MUL_W'(n) << 1;
            default: return MUL_W'(n) << 2;
        endcase
    endfunction

endpackage

// File: rtl/dmaf_hs_cond.sv
module dmaf_hs_cond
    import dmaf_pkg::*;
(
    input  logic raw_single,
    input  logic raw_burst,
    input  logic pol,
    input  logic is_mem,
    output hs_t  hs
);
    logic single_on, burst_on;

    always_comb begin
        single_on = raw_single ^ pol;
        burst_on  = raw_burst ^ pol;
        hs.act    = single_on | burst_on;
        hs.burst  = is_mem | burst_on;
    end
endmodule

// File: rtl/dmaf_fifo_ready.sv
module dmaf_fifo_ready
    import dmaf_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter bit IS_DST = 1'b0
) (
    input  logic [CNT_W-1:0]  level,
    input  wid_e              own_w,
    input  wid_e              alt_w,
    input  logic [BL_W-1:0]   blen,
    input  logic [LEFT_W-1:0] left,
    input  logic              fifo_mode,
    input  logic              flush,
    input  logic              suspend,
    input  logic              burst_txn,
    output logic              ready
);
    localparam int                HALF    = DEPTH / 2;
    localparam logic [CNT_W-1:0]  DEPTH_C = CNT_W'(DEPTH);
    localparam logic [LEFT_W-1:0] HALF_C  = LEFT_W'(HALF);

    logic             fallback, use_burst;
    logic [MUL_W-1:0] avail, single_need, burst_need;

    always_comb begin
        fallback   = (left < HALF_C) || flush || suspend;
        use_burst  = fifo_mode && burst_txn && !fallback;
        burst_need = burst_bytes(blen, own_w);
    end

    generate
        if (IS_DST) begin : g_data
            // destination side counts stored bytes; flush drains by source width
            always_comb begin
                avail       = MUL_W'(level);
                single_need = flush ? item_bytes(alt_w) : item_bytes(own_w);
            end
            logic unused_dst;
            assign unused_dst = 1'b0;
        end else begin : g_space
            // source side counts free bytes
            always_comb begin
                avail       = (level >= DEPTH_C) ? '0 : MUL_W'(DEPTH_C - level);
                single_need = item_bytes(own_w);
            end
            logic unused_alt;
            assign unused_alt = ^alt_w;
        end
    endgenerate

    always_comb ready = use_burst ? (avail >= burst_need) : (avail >= single_need);
endmodule

// File: rtl/dmaf_req_hold.sv
module dmaf_req_hold (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic raise,
    input  logic grant,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst || !en)
            req <= 1'b0;
        else if (req)
            req <= !grant;
        else
            req <= raise;
    end
endmodule

// File: rtl/dma_chan_req_gate.sv
module dma_chan_req_gate
    import dmaf_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic [CNT_W-1:0]  fifo_bytes,
    input  logic [1:0]        src_wsel,
    input  logic [1:0]        dst_wsel,
    input  logic [BL_W-1:0]   src_blen,
    input  logic [BL_W-1:0]   dst_blen,
    input  logic [LEFT_W-1:0] src_left,
    input  logic [LEFT_W-1:0] dst_left,
    input  logic              fifo_mode,
    input  logic              flush,
    input  logic              suspend,
    input  logic              src_is_mem,
    input  logic              dst_is_mem,
    input  logic              dst_is_fc,
    input  logic              prefetch_off,
    input  logic              src_hs_pol,
    input  logic              dst_hs_pol,
    input  logic              src_hs_single,
    input  logic              src_hs_burst,
    input  logic              dst_hs_single,
    input  logic              dst_hs_burst,
    input  logic              src_grant,
    input  logic              dst_grant,
    output logic              src_req,
    output logic              dst_req,
    output logic              fifo_empty
);
    localparam int DEPTH = depth_for(CHAN_ID);

    wid_e w_src, w_dst;
    hs_t  hs_src, hs_dst;
    logic rdy_src, rdy_dst;
    logic raise_src, raise_dst;
    logic empty_nx;

    assign w_src = wid_e'(src_wsel);
    assign w_dst = wid_e'(dst_wsel);

    dmaf_hs_cond u_hs_src (
        .raw_single (src_hs_single),
        .raw_burst  (src_hs_burst),
        .pol        (src_hs_pol),
        .is_mem     (src_is_mem),
        .hs         (hs_src)
    );

    dmaf_hs_cond u_hs_dst (
        .raw_single (dst_hs_single),
        .raw_burst  (dst_hs_burst),
        .pol        (dst_hs_pol),
        .is_mem     (dst_is_mem),
        .hs         (hs_dst)
    );

    dmaf_fifo_ready #(.DEPTH(DEPTH), .IS_DST(1'b0)) u_rdy_src (
        .level     (fifo_bytes),
        .own_w     (w_src),
        .alt_w     (w_dst),
        .blen      (src_blen),
        .left      (src_left),
        .fifo_mode (fifo_mode),
        .flush     (flush),
        .suspend   (suspend),
        .burst_txn (hs_src.burst),
        .ready     (rdy_src)
    );

    dmaf_fifo_ready #(.DEPTH(DEPTH), .IS_DST(1'b1)) u_rdy_dst (
        .level     (fifo_bytes),
        .own_w     (w_dst),
        .alt_w     (w_src),
        .blen      (dst_blen),
        .left      (dst_left),
        .fifo_mode (fifo_mode),
        .flush     (flush),
        .suspend   (suspend),
        .burst_txn (hs_dst.burst),
        .ready     (rdy_dst)
    );

    always_comb begin
        raise_src = rdy_src && !suspend
                 && (src_is_mem || hs_src.act)
                 && (!(dst_is_fc && prefetch_off) || hs_dst.act);
        raise_dst = rdy_dst && (dst_is_mem || hs_dst.act);
        empty_nx  = (fifo_bytes == '0)
                 || (suspend && (item_bytes(w_src) < item_bytes(w_dst))
                     && (MUL_W'(fifo_bytes) < item_bytes(w_dst)));
    end

    dmaf_req_hold u_hold_src (
        .clk   (clk),
        .rst   (rst),
        .en    (chan_en),
        .raise (raise_src),
        .grant (src_grant),
        .req   (src_req)
    );

    dmaf_req_hold u_hold_dst (
        .clk   (clk),
        .rst   (rst),
        .en    (chan_en),
        .raise (raise_dst),
        .grant (dst_grant),
        .req   (dst_req)
    );

    always_ff @(posedge clk) begin
        if (rst) fifo_empty <= 1'b0;
        else     fifo_empty <= empty_nx;
    end
endmodule

// File: rtl/dmaf_chk.sv
module dmaf_chk
    import dmaf_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             chan_en,
    input logic [CNT_W-1:0] fifo_bytes,
    input logic             suspend,
    input logic             src_is_mem,
    input logic             src_hs_pol,
    input logic             src_hs_single,
    input logic             src_hs_burst,
    input logic             src_grant,
    input logic             dst_grant,
    input logic             src_req,
    input logic             dst_req,
    input logic             fifo_empty
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic src_line_on;
    assign src_line_on = (src_hs_single != src_hs_pol) || (src_hs_burst != src_hs_pol);

    AST_RST_IDLE: assert property (@(posedge clk)
        rst |=> (!src_req && !dst_req && !fifo_empty));                           // R1
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> (!src_req && !dst_req));                                    // R1
    AST_FULL_NO_SRC: assert property (@(posedge clk) disable iff (rst)
        (fifo_bytes >= DEPTH_C && !src_req) |=> !src_req);                       // R2
    AST_SUSP_NO_SRC: assert property (@(posedge clk) disable iff (rst)
        (suspend && !src_req) |=> !src_req);                                     // R7
    AST_NO_LINE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (!src_is_mem && !src_line_on && !src_req) |=> !src_req);                 // R8
    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (src_req && !src_grant && chan_en) |=> src_req);                         // R10
    AST_SRC_DROP: assert property (@(posedge clk) disable iff (rst)
        (src_req && src_grant) |=> !src_req);                                    // R10
    AST_DST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dst_req && !dst_grant && chan_en) |=> dst_req);                         // R10
    AST_DST_DROP: assert property (@(posedge clk) disable iff (rst)
        (dst_req && dst_grant) |=> !dst_req);                                    // R10
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (fifo_bytes == '0) |=> fifo_empty);                                      // R11
endmodule

bind dma_chan_req_gate dmaf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .chan_en       (chan_en),
    .fifo_bytes    (fifo_bytes),
    .suspend       (suspend),
    .src_is_mem    (src_is_mem),
    .src_hs_pol    (src_hs_pol),
    .src_hs_single (src_hs_single),
    .src_hs_burst  (src_hs_burst),
    .src_grant     (src_grant),
    .dst_grant     (dst_grant),
    .src_req       (src_req),
    .dst_req       (dst_req),
    .fifo_empty    (fifo_empty)
);

// File: tb/dma_chan_req_gate_tb.sv
module dma_chan_req_gate_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_en = 1'b0;
    logic [7:0]  fifo_bytes = '0;
    logic [1:0]  src_wsel = '0, dst_wsel = '0;
    logic [7:0]  src_blen = 8'd8, dst_blen = 8'd8;
    logic [15:0] src_left = 16'd100, dst_left = 16'd100;
    logic fifo_mode = 0, flush = 0, suspend = 0, src_is_mem = 1, dst_is_mem = 1;
    logic dst_is_fc = 0, prefetch_off = 0, src_hs_pol = 0, dst_hs_pol = 0;
    logic src_hs_single = 0, src_hs_burst = 0, dst_hs_single = 0, dst_hs_burst = 0;
    logic src_grant = 0, dst_grant = 0;
    logic src_req, dst_req, fifo_empty;
    logic sm_src_req, sm_dst_req, sm_fifo_empty;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dma_chan_req_gate #(.CHAN_ID(0)) u_dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .fifo_bytes(fifo_bytes),
        .src_wsel(src_wsel), .dst_wsel(dst_wsel), .src_blen(src_blen), .dst_blen(dst_blen),
        .src_left(src_left), .dst_left(dst_left), .fifo_mode(fifo_mode), .flush(flush),
        .suspend(suspend), .src_is_mem(src_is_mem), .dst_is_mem(dst_is_mem),
        .dst_is_fc(dst_is_fc), .prefetch_off(prefetch_off), .src_hs_pol(src_hs_pol),
        .dst_hs_pol(dst_hs_pol), .src_hs_single(src_hs_single), .src_hs_burst(src_hs_burst),
        .dst_hs_single(dst_hs_single), .dst_hs_burst(dst_hs_burst), .src_grant(src_grant),
        .dst_grant(dst_grant), .src_req(src_req), .dst_req(dst_req), .fifo_empty(fifo_empty)
    );

    dma_chan_req_gate #(.CHAN_ID(2)) u_dut_small (
        .clk(clk), .rst(rst), .chan_en(chan_en), .fifo_bytes(fifo_bytes),
        .src_wsel(src_wsel), .dst_wsel(dst_wsel), .src_blen(src_blen), .dst_blen(dst_blen),
        .src_left(src_left), .dst_left(dst_left), .fifo_mode(fifo_mode), .flush(flush),
        .suspend(suspend), .src_is_mem(src_is_mem), .dst_is_mem(dst_is_mem),
        .dst_is_fc(dst_is_fc), .prefetch_off(prefetch_off), .src_hs_pol(src_hs_pol),
        .dst_hs_pol(dst_hs_pol), .src_hs_single(src_hs_single), .src_hs_burst(src_hs_burst),
        .dst_hs_single(dst_hs_single), .dst_hs_burst(dst_hs_burst), .src_grant(src_grant),
        .dst_grant(dst_grant), .src_req(sm_src_req), .dst_req(sm_dst_req),
        .fifo_empty(sm_fifo_empty)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [7:0]  by;
        logic [1:0]  sw, dw;
        logic [7:0]  sbl, dbl;
        logic [15:0] lf;
        logic        md, fl, su, sm, dm;
        logic [1:0]  sh, dh;   // {burst line, single line}
        logic        es, ed, ee;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        // R2: free 4 fits one 4-byte item; 125 stored leaves 3
        '{4'd2, 8'd124, 2'd2, 2'd2, 8'd8, 8'd8, 16'd100, 1'b0,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b1,1'b0},
        '{4'd2, 8'd125, 2'd2, 2'd2, 8'd8, 8'd8, 16'd100, 1'b0,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b0,1'b1,1'b0},
        // R3: 3 bytes < 4-byte item; 1 byte = 1-byte item
        '{4'd3, 8'd3,   2'd0, 2'd2, 8'd8, 8'd8, 16'd100, 1'b0,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b0,1'b0},
        '{4'd3, 8'd1,   2'd0, 2'd0, 8'd8, 8'd8, 16'd100, 1'b0,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b1,1'b0},
        // R4: flush judges destination by source width
        '{4'd4, 8'd1,   2'd0, 2'd2, 8'd8, 8'd8, 16'd100, 1'b0,1'b1,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b1,1'b0},
        '{4'd4, 8'd1,   2'd1, 2'd2, 8'd8, 8'd8, 16'd100, 1'b0,1'b1,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b0,1'b0},
        // R5: burst thresholds 8 x 4 = 32 bytes
        '{4'd5, 8'd100, 2'd2, 2'd2, 8'd8, 8'd8, 16'd100, 1'b1,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b0,1'b1,1'b0},
        '{4'd5, 8'd96,  2'd2, 2'd2, 8'd8, 8'd8, 16'd100, 1'b1,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b1,1'b0},
        '{4'd5, 8'd31,  2'd2, 2'd2, 8'd8, 8'd8, 16'd100, 1'b1,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b0,1'b0},
        // R6: items left below 64 fall back, 64 does not
        '{4'd6, 8'd31,  2'd2, 2'd2, 8'd8, 8'd8, 16'd10,  1'b1,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b1,1'b0},
        '{4'd6, 8'd100, 2'd2, 2'd2, 8'd8, 8'd8, 16'd63,  1'b1,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b1,1'b0},
        '{4'd6, 8'd100, 2'd2, 2'd2, 8'd8, 8'd8, 16'd64,  1'b1,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b0,1'b1,1'b0},
        // R5: peripherals, single lines keep plain test, burst lines use threshold
        '{4'd5, 8'd31,  2'd2, 2'd2, 8'd8, 8'd8, 16'd100, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1,2'd1, 1'b1,1'b1,1'b0},
        '{4'd5, 8'd31,  2'd2, 2'd2, 8'd8, 8'd8, 16'd100, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd2, 1'b1,1'b0,1'b0},
        // R8: peripherals without any active line
        '{4'd8, 8'd50,  2'd0, 2'd0, 8'd8, 8'd8, 16'd100, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0,1'b0},
        // R7: suspend blocks source, destination drains by plain test
        '{4'd7, 8'd20,  2'd2, 2'd2, 8'd8, 8'd8, 16'd100, 1'b1,1'b0,1'b1,1'b1,1'b1, 2'd0,2'd0, 1'b0,1'b1,1'b0},
        // R11: suspended narrow-to-wide leftover counts as empty
        '{4'd11,8'd3,   2'd0, 2'd2, 8'd8, 8'd8, 16'd100, 1'b0,1'b0,1'b1,1'b1,1'b1, 2'd0,2'd0, 1'b0,1'b0,1'b1},
        '{4'd11,8'd3,   2'd0, 2'd2, 8'd8, 8'd8, 16'd100, 1'b0,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b0,1'b0},
        '{4'd11,8'd0,   2'd2, 2'd2, 8'd8, 8'd8, 16'd100, 1'b0,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b0,1'b1},
        // R4: flush overrides threshold mode
        '{4'd4, 8'd20,  2'd2, 2'd2, 8'd8, 8'd8, 16'd100, 1'b1,1'b1,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b1,1'b1,1'b0}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // one off-cycle, one on-cycle; caller stands just after a falling edge
    task automatic step_on();
        chan_en = 1'b0;
        @(negedge clk);
        chan_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk3(input string tag, input logic es, input logic ed, input logic ee);
        chk({tag, " src_req"}, src_req, es);
        chk({tag, " dst_req"}, dst_req, ed);
        chk({tag, " fifo_empty"}, fifo_empty, ee);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk3("R1 reset", 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            fifo_bytes = VEC[i].by;  src_wsel = VEC[i].sw;  dst_wsel = VEC[i].dw;
            src_blen = VEC[i].sbl;   dst_blen = VEC[i].dbl;
            src_left = VEC[i].lf;    dst_left = VEC[i].lf;
            fifo_mode = VEC[i].md;   flush = VEC[i].fl;     suspend = VEC[i].su;
            src_is_mem = VEC[i].sm;  dst_is_mem = VEC[i].dm;
            {src_hs_burst, src_hs_single} = VEC[i].sh;
            {dst_hs_burst, dst_hs_single} = VEC[i].dh;
            step_on();
            chk3($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].es, VEC[i].ed, VEC[i].ee);
        end

        // R8: polarity, active-low lines
        fifo_mode = 0; flush = 0; suspend = 0; fifo_bytes = 8'd0;
        src_wsel = 2'd0; dst_wsel = 2'd0; src_left = 16'd100; dst_left = 16'd100;
        src_is_mem = 0; dst_is_mem = 1; src_hs_pol = 1;
        {src_hs_burst, src_hs_single} = 2'b11;
        step_on();
        chk("R8 pol lines high", src_req, 1'b0);
        {src_hs_burst, src_hs_single} = 2'b00;
        step_on();
        chk("R8 pol lines low", src_req, 1'b1);
        src_hs_pol = 0; {src_hs_burst, src_hs_single} = 2'b00;

        // R9: prefetch inhibit waits for destination line
        src_is_mem = 1; dst_is_mem = 0; dst_is_fc = 1; prefetch_off = 1;
        step_on();
        chk("R9 no dst line src_req", src_req, 1'b0);
        dst_hs_single = 1;
        step_on();
        chk("R9 dst line src_req", src_req, 1'b1);
        dst_hs_single = 0; dst_is_fc = 0; prefetch_off = 0; dst_is_mem = 1;

        // R10: hold until grant
        fifo_bytes = 8'd0;
        step_on();
        chk("R10 raised", src_req, 1'b1);
        fifo_bytes = 8'd128;
        @(negedge clk);
        chk("R10 held while not ready", src_req, 1'b1);
        src_grant = 1;
        @(negedge clk);
        chk("R10 dropped after grant", src_req, 1'b0);
        src_grant = 0;
        @(negedge clk);
        chk("R10 stays low when not ready", src_req, 1'b0);
        fifo_bytes = 8'd0;
        @(negedge clk);
        chk("R10 re-raised", src_req, 1'b1);
        chan_en = 0;
        @(negedge clk);
        chk("R1 disable clears src_req", src_req, 1'b0);

        // R12: 32-byte channel, half depth 16
        src_wsel = 2'd2; fifo_mode = 0; fifo_bytes = 8'd29;
        step_on();
        chk("R12 small free 3", sm_src_req, 1'b0);
        chk("R12 large free 99", src_req, 1'b1);
        fifo_bytes = 8'd28;
        step_on();
        chk("R12 small free 4", sm_src_req, 1'b1);
        fifo_mode = 1; src_blen = 8'd8; fifo_bytes = 8'd10; src_left = 16'd15;
        step_on();
        chk("R12 small left 15 falls back", sm_src_req, 1'b1);
        src_left = 16'd16;
        step_on();
        chk("R12 small left 16 threshold", sm_src_req, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule